// File: doc/BRIEF.md
# Lane Frame-End Character Replacer

This block sits in the transmit path of an 8b/10b converter link that carries multi-octet frames. It sits just before the encoder. While the link is held in its synchronization phase, it sends nothing but the K28.5 comma. Once data flows, it marks frame ends by swapping the last octet of a frame for the K28.7 control character under a mode-dependent rule:

- **Scrambled mode:** an end octet of 0xFC is swapped.
- **Unscrambled mode:** an end octet that repeats the previous frame's end octet is swapped.

The block counts frame positions itself from a frame-length parameter. It flags the frame-end character on its output.

The same module also holds the matching receive-side restorer. The restorer puts the original octet back in place of each frame-end K28.7. It also reports when comma realignment may stay enabled, which is only during the receiver's synchronization phase, because K28.7 turns up in normal data.

Top module: `lane_char_replacer`

## Requirements
- R1: While `sync_req` is sampled high, the next transmit character is 0xBC (K28.5) with `tx_k` high and `tx_eof` low.
- R2: In unscrambled mode, a frame-end octet equal to the previous frame's end octet is sent as 0xFC with `tx_k` high.
- R3: In scrambled mode, a frame-end octet of 0xFC is sent as 0xFC with `tx_k` high.
- R4: Every other data-phase octet is sent unchanged with `tx_k` low, including 0xFC or repeats at positions that are not the frame end.
- R5: In unscrambled mode, the first frame after the synchronization phase is never substituted, whatever its end octet.
- R6: `scram_sel` (1 = scrambled, 0 = unscrambled) is taken only during the synchronization phase. Changes during the data phase have no effect.
- R7: The transmitter has one cycle of latency. Frame positions start at 0 on the first data cycle, and `tx_eof` is high on the character for position FRAME_LEN-1.
- R8: The receiver has one cycle of latency. It restores a frame-end K28.7 to the previous frame's end octet (unscrambled mode) or to 0xFC (scrambled mode), with `rx_k_o` low. It passes synchronization-phase characters through unchanged.
- R9: `comma_align_en` is high exactly while `rx_sync` is high.
- R10: After reset, all character, K and frame-end outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Transmitter in synchronization phase |
| scram_sel | input | 1 | Mode select: 1 scrambled, 0 unscrambled |
| tx_octet | input | 8 | Octet to transmit |
| tx_char | output | 8 | Character toward the encoder |
| tx_k | output | 1 | Control-character flag for `tx_char` |
| tx_eof | output | 1 | `tx_char` is at the last frame position |
| rx_sync | input | 1 | Receiver in synchronization phase |
| rx_char | input | 8 | Decoded received character |
| rx_k | input | 1 | Control flag of `rx_char` |
| rx_octet | output | 8 | Restored octet |
| rx_k_o | output | 1 | Control flag after restoration |
| rx_eof | output | 1 | `rx_octet` is at the last frame position |
| comma_align_en | output | 1 | Comma realignment permitted |

## Verification
The assertions assume that the data phase starts with frame position 0. They also assume that the receiver's mode is taken from the same `scram_sel` level as the transmitter's.

The bench loops the transmit output back to the receive input, with `rx_sync` following `sync_req` one cycle later. It holds `scram_sel` steady through each synchronization phase and through the first receive cycle after it. It toggles `scram_sel` only later in a data phase, and only for the mode-ignore test.

// File: rtl/lane_char_replacer.sv
module lane_char_replacer #(
  parameter int FRAME_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_req,
  input  logic       scram_sel,
  input  logic [7:0] tx_octet,
  output logic [7:0] tx_char,
  output logic       tx_k,
  output logic       tx_eof,
  input  logic       rx_sync,
  input  logic [7:0] rx_char,
  input  logic       rx_k,
  output logic [7:0] rx_octet,
  output logic       rx_k_o,
  output logic       rx_eof,
  output logic       comma_align_en
);
  localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_LEN - 1);
  localparam logic [7:0] COMMA = 8'hBC;
  localparam logic [7:0] FEND  = 8'hFC;

  logic [CW-1:0] tcnt, rcnt;
  logic [7:0]    tprev, rprev;
  logic          tpv, tmode, rmode;

  wire t_last = (tcnt == LAST_POS);
  wire t_sub  = t_last && (tmode ? (tx_octet == FEND) : (tpv && tx_octet == tprev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_char <= '0; tx_k <= 1'b0; tx_eof <= 1'b0;
      tcnt <= '0; tprev <= '0; tpv <= 1'b0; tmode <= 1'b0;
    end else if (sync_req) begin
      tx_char <= COMMA; tx_k <= 1'b1; tx_eof <= 1'b0;
      tcnt <= '0; tpv <= 1'b0; tmode <= scram_sel;
    end else begin
      tx_char <= t_sub ? FEND : tx_octet;
      tx_k    <= t_sub;
      tx_eof  <= t_last;
      tcnt    <= t_last ? '0 : tcnt + CW'(1);
      if (t_last) begin
        tprev <= tx_octet;
        tpv   <= 1'b1;
      end
    end
  end

  wire       r_last = (rcnt == LAST_POS);
  wire       r_hit  = r_last && rx_k && (rx_char == FEND);
  wire [7:0] r_val  = r_hit ? (rmode ? FEND : rprev) : rx_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_octet <= '0; rx_k_o <= 1'b0; rx_eof <= 1'b0;
      rcnt <= '0; rprev <= '0; rmode <= 1'b0;
    end else if (rx_sync) begin
      rx_octet <= rx_char; rx_k_o <= rx_k; rx_eof <= 1'b0;
      rcnt <= '0; rprev <= '0; rmode <= scram_sel;
    end else begin
      rx_octet <= r_val;
      rx_k_o   <= rx_k && !r_hit;
      rx_eof   <= r_last;
      rcnt     <= r_last ? '0 : rcnt + CW'(1);
      if (r_last) rprev <= r_val;
    end
  end

  assign comma_align_en = rx_sync;
endmodule

module lane_char_replacer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_req,
  input logic [7:0] tx_char,
  input logic       tx_k,
  input logic       tx_eof,
  input logic [7:0] rx_octet,
  input logic       rx_k_o,
  input logic       rx_eof,
  input logic       tmode
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  assert_sync_comma_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(sync_req)) |-> (tx_char == 8'hBC && tx_k && !tx_eof));

  assert_k_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_k |-> (tx_char == 8'hBC || tx_char == 8'hFC));

  assert_fend_at_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k && tx_char == 8'hFC) |-> tx_eof);

  assert_rx_restored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |-> !(rx_k_o && rx_octet == 8'hFC));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(sync_req)) |-> $stable(tmode));
endmodule

bind lane_char_replacer lane_char_replacer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .tx_char(tx_char), .tx_k(tx_k),
  .tx_eof(tx_eof), .rx_octet(rx_octet), .rx_k_o(rx_k_o), .rx_eof(rx_eof), .tmode(tmode)
);

// File: tb/lane_char_replacer_bench.sv
module lane_char_replacer_bench;
  localparam int FL = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_req = 1'b1, scram_sel = 1'b0, rx_sync = 1'b1;
  logic [7:0] tx_octet = '0;
  logic [7:0] tx_char, rx_octet;
  logic tx_k, tx_eof, rx_k_o, rx_eof, comma_align_en;

  always #2.5 clk = ~clk;

  lane_char_replacer #(.FRAME_LEN(FL)) u_lane_char_replacer (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .scram_sel(scram_sel),
    .tx_octet(tx_octet), .tx_char(tx_char), .tx_k(tx_k), .tx_eof(tx_eof),
    .rx_sync(rx_sync), .rx_char(tx_char), .rx_k(tx_k), .rx_octet(rx_octet),
    .rx_k_o(rx_k_o), .rx_eof(rx_eof), .comma_align_en(comma_align_en));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_cnt = 0;
  logic [7:0] m_prev = '0;
  bit m_pv = 0, m_mode = 0;
  logic [7:0] e_ch; bit e_k, e_eof, have_e = 0;
  string e_tag;
  bit p1v = 0, p1s = 0, p1l = 0, p2v = 0, p2s = 0, p2l = 0;
  logic [7:0] p1d = '0, p2d = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit sel, input logic [7:0] d);
    bit last, sub;
    @(negedge clk);
    if (have_e) begin
      chk(tx_char == e_ch && tx_k == e_k, e_tag, {tx_k, tx_char}, {e_k, e_ch});
      chk(tx_eof == e_eof, "R7 tx_eof", tx_eof, e_eof);
    end
    if (p2v) begin
      if (p2s) chk(rx_octet == 8'hBC && rx_k_o && !rx_eof, "R8 rx sync pass",
                   {rx_eof, rx_k_o, rx_octet}, {1'b0, 1'b1, 8'hBC});
      else chk(rx_octet == p2d && !rx_k_o && rx_eof == p2l, "R8 rx restore",
               {rx_eof, rx_k_o, rx_octet}, {p2l, 1'b0, p2d});
    end
    chk(comma_align_en == rx_sync, "R9 comma_align_en", comma_align_en, rx_sync);
    rx_sync = sync_req;
    sync_req = s; scram_sel = sel; tx_octet = d;
    last = 0;
    if (s) begin
      e_ch = 8'hBC; e_k = 1; e_eof = 0; e_tag = "R1 sync comma";
      m_mode = sel; m_pv = 0; m_cnt = 0;
    end else begin
      last = (m_cnt == FL - 1);
      sub = last && (m_mode ? (d == 8'hFC) : (m_pv && d == m_prev));
      e_ch = sub ? 8'hFC : d; e_k = sub; e_eof = last;
      if (sel != m_mode) e_tag = "R6 mode ignored in data";
      else if (last && !m_mode && !m_pv) e_tag = "R5 first frame";
      else if (sub) e_tag = m_mode ? "R3 scrambled subst" : "R2 unscrambled subst";
      else e_tag = "R4 pass-through";
      if (last) begin m_prev = d; m_pv = 1; end
      m_cnt = last ? 0 : m_cnt + 1;
    end
    have_e = 1;
    p2v = p1v; p2s = p1s; p2d = p1d; p2l = p1l;
    p1v = 1; p1s = s; p1d = d; p1l = last;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    bit sel;
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_char == 0 && !tx_k && !tx_eof && rx_octet == 0 && !rx_k_o && !rx_eof,
        "R10 reset state", {tx_k, tx_eof, tx_char}, 0);
    rst_n = 1'b1;
    for (int ep = 0; ep < 14; ep++) begin
      sel = ep[0];
      for (int i = 0; i < 3; i++) step(1'b1, sel, 8'h00);
      for (int i = 0; i < 48; i++) begin
        if (ep == 0) d = 8'h00;
        else if (ep == 1) d = 8'hFC;
        else if (ep == 2) d = 8'h5A;
        else begin
          case ($urandom % 4)
            0: d = 8'hFC;
            1: d = m_prev;
            default: d = 8'($urandom);
          endcase
        end
        if (ep % 4 == 2 && i > 2) step(1'b0, 1'($urandom), d);
        else step(1'b0, sel, d);
      end
    end
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule